// File: doc/BRIEF.md
# Coupling-Aware Link Inversion Encoder

This block sits at the transmit end of a network-on-chip link. It accepts one data flit per cycle through a valid/ready handshake. It codes the flit into a link word that it holds on the wires until the next flit replaces it. For every flit it builds four candidate link words: the data unchanged, the data with odd-indexed bits complemented, the data with even-indexed bits complemented, and the data fully complemented. It scores each candidate against the word currently on the wires and drives the cheapest one.

The score is a weighted count of wire activity across the whole link word, mode wires included. Each toggling wire adds one. A neighbouring pair where only one wire toggles adds one. A neighbouring pair whose wires toggle in opposite directions adds two. Pairs that toggle together, and pairs where neither wire moves, add nothing. A two-bit mode field travels with the payload, so the receiver can undo the transform with a single XOR mask.

Top module: `lie_encoder`

## Requirements
- R1: After reset, out_valid is 0, out_word is all zeros and in_ready is 1.
- R2: The link word is {mode[1:0], payload[DATA_W-1:0]}, with mode in the top two bits: 00 none, 01 odd, 10 even, 11 full. The payload is the data XOR a mask. The mask is empty for none, has ones at odd indices for odd, has ones at even indices (index 0 is even) for even, and is all ones for full.
- R3: A candidate's cost is taken over all DATA_W+2 wires against the reference word. Each toggling wire adds 1. Each adjacent pair with exactly one toggling wire adds 1. Each adjacent pair toggling in opposite directions adds 2.
- R4: The driven word has the lowest cost of the four candidates. On equal cost, none beats odd, odd beats even, and even beats full.
- R5: The reference word is the link word last driven. It is zero after reset and keeps its value when no flit is accepted, including while out_valid is low.
- R6: in_ready is high exactly when no word is pending or out_ready is high. An accepted flit appears on out_word with out_valid high on the next cycle.
- R7: While out_valid is high and out_ready is low, out_word and out_valid hold their values.
- R8: XORing the payload of a driven word with the mask selected by its mode field gives back the accepted data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Encoder can take a flit |
| in_data | input | DATA_W | Input flit data |
| out_valid | output | 1 | Link word is a new flit |
| out_ready | input | 1 | Link side accepts the word |
| out_word | output | DATA_W+2 | Coded link word, mode in top two bits |

## Verification
A four-bit configuration is driven with every ordered pair of flit values sent back to back. This pairs every possible reference word reached in operation with every data value. It separates correct cost weighting from plain toggle counting, and correct tie order from any other order. A single flit after reset pins down the even-inversion choice with exact costs. A drain followed by a stalled transfer shows that the held wires, not the last accepted data, serve as the reference, and that backpressure freezes the link.

// File: rtl/lie_pkg.sv
package lie_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_ODD  = 2'b01,
    MODE_EVEN = 2'b10,
    MODE_FULL = 2'b11
  } inv_mode_e;

  localparam int NUM_CAND = 4;
endpackage

// File: rtl/lie_candidate.sv
module lie_candidate #(
  parameter int DATA_W = 32,
  parameter logic [1:0] MODE = 2'b00,
  parameter int COST_W = 8,
  localparam int LINK_W = DATA_W + 2
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LINK_W-1:0] ref_word,
  output logic [LINK_W-1:0] cand_word,
  output logic [COST_W-1:0] cand_cost
);
  import lie_pkg::*;

  function automatic logic [DATA_W-1:0] inv_mask(input logic [1:0] m);
    logic [DATA_W-1:0] k;
    for (int i = 0; i < DATA_W; i++) begin
      case (m)
        MODE_ODD:  k[i] = (i % 2) == 1;
        MODE_EVEN: k[i] = (i % 2) == 0;
        MODE_FULL: k[i] = 1'b1;
        default:   k[i] = 1'b0;
      endcase
    end
    return k;
  endfunction

  function automatic logic [COST_W-1:0] link_cost(input logic [LINK_W-1:0] a,
                                                  input logic [LINK_W-1:0] b);
    logic [LINK_W-1:0] tog, rise;
    logic [COST_W-1:0] c;
    tog = a ^ b;
    rise = ~a & b;
    c = '0;
    for (int i = 0; i < LINK_W; i++)
      if (tog[i]) c = c + COST_W'(1);
    for (int i = 0; i < LINK_W - 1; i++) begin
      if (tog[i] ^ tog[i+1]) c = c + COST_W'(1);
      else if (tog[i] && (rise[i] != rise[i+1])) c = c + COST_W'(2);
    end
    return c;
  endfunction

  always_comb begin
    cand_word = {MODE, data ^ inv_mask(MODE)};
    cand_cost = link_cost(ref_word, cand_word);
  end
endmodule

// File: rtl/lie_select.sv
module lie_select #(
  parameter int LINK_W = 34,
  parameter int COST_W = 8
) (
  input  logic [LINK_W-1:0] words [lie_pkg::NUM_CAND],
  input  logic [COST_W-1:0] costs [lie_pkg::NUM_CAND],
  output logic [LINK_W-1:0] best_word,
  output logic [COST_W-1:0] best_cost,
  output logic [1:0]        best_idx
);
  always_comb begin
    best_word = words[0];
    best_cost = costs[0];
    best_idx  = 2'd0;
    for (int i = 1; i < lie_pkg::NUM_CAND; i++) begin
      if (costs[i] < best_cost) begin
        best_word = words[i];
        best_cost = costs[i];
        best_idx  = 2'(i);
      end
    end
  end
endmodule

// File: rtl/lie_out_reg.sv
module lie_out_reg #(
  parameter int LINK_W = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LINK_W-1:0] next_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [LINK_W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      if (load) begin
        out_valid <= 1'b1;
        out_word  <= next_word;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lie_encoder.sv
module lie_encoder #(
  parameter int DATA_W = 32,
  localparam int LINK_W = DATA_W + 2,
  localparam int COST_W = $clog2(3 * LINK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINK_W-1:0] out_word
);
  import lie_pkg::*;

  logic [LINK_W-1:0] cand_word [NUM_CAND];
  logic [COST_W-1:0] cand_cost [NUM_CAND];
  logic [LINK_W-1:0] best_word;
  logic [COST_W-1:0] best_cost;
  logic [1:0]        best_idx;
  logic              accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
    lie_candidate #(
      .DATA_W(DATA_W),
      .MODE  (2'(g)),
      .COST_W(COST_W)
    ) u_cand (
      .data     (in_data),
      .ref_word (out_word),
      .cand_word(cand_word[g]),
      .cand_cost(cand_cost[g])
    );
  end

  lie_select #(.LINK_W(LINK_W), .COST_W(COST_W)) u_sel (
    .words    (cand_word),
    .costs    (cand_cost),
    .best_word(best_word),
    .best_cost(best_cost),
    .best_idx (best_idx)
  );

  lie_out_reg #(.LINK_W(LINK_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .next_word(best_word),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_word (out_word)
  );

  function automatic logic [DATA_W-1:0] rx_mask(input logic [1:0] m);
    logic [DATA_W-1:0] k;
    for (int i = 0; i < DATA_W; i++)
      k[i] = (m == MODE_FULL) || (m == MODE_ODD && i[0]) || (m == MODE_EVEN && !i[0]);
    return k;
  endfunction

  p_min_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (best_cost <= cand_cost[0]) && (best_cost <= cand_cost[1]) &&
               (best_cost <= cand_cost[2]) && (best_cost <= cand_cost[3]));

  p_tie_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && best_idx != 2'd0) |-> cand_cost[0] > best_cost);

  p_accept_shows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && out_word == $past(best_word));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_word));

  p_ref_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(out_word));

  p_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_word[DATA_W-1:0] ^ rx_mask(out_word[LINK_W-1:DATA_W])) == $past(in_data));
endmodule

// File: tb/sim_lie_encoder.sv
module sim_lie_encoder;
  localparam int DW = 4;
  localparam int LW = DW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [LW-1:0] out_word;

  int checks = 0;
  int errors = 0;
  logic [LW-1:0] mprev = '0;

  always #10 clk = ~clk;

  lie_encoder #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 masks, restated as arithmetic on indices
  function automatic logic [DW-1:0] mask_of(input int m);
    logic [DW-1:0] k = '0;
    for (int i = 0; i < DW; i++)
      if (m == 3 || (m == 1 && i % 2 == 1) || (m == 2 && i % 2 == 0)) k[i] = 1'b1;
    return k;
  endfunction

  // R3 cost restated: self toggles plus pairwise coupling weights
  function automatic int cost_of(input logic [LW-1:0] p, input logic [LW-1:0] n);
    int c = 0;
    for (int i = 0; i < LW; i++) c += (p[i] != n[i]) ? 1 : 0;
    for (int i = 0; i + 1 < LW; i++) begin
      bit ta = p[i] != n[i];
      bit tb = p[i+1] != n[i+1];
      if (ta != tb) c += 1;
      if (ta && tb && n[i] != n[i+1]) c += 2;
    end
    return c;
  endfunction

  // R4 choice with tie order none, odd, even, full
  function automatic logic [LW-1:0] model(input logic [DW-1:0] d);
    logic [LW-1:0] best = '0;
    int bc = 1 << 30;
    for (int m = 0; m < 4; m++) begin
      logic [LW-1:0] w = {2'(m), d ^ mask_of(m)};
      int c = cost_of(mprev, w);
      if (c < bc) begin bc = c; best = w; end
    end
    return best;
  endfunction

  task automatic send(input logic [DW-1:0] d, input string tag);
    logic [LW-1:0] exp;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    exp = model(d);
    mprev = exp;
    chk(out_valid && out_word == exp, tag, int'(out_word), int'(exp));
    chk((out_word[DW-1:0] ^ mask_of(int'(out_word[LW-1:DW]))) == d, "R8 decode",
        int'(out_word[DW-1:0] ^ mask_of(int'(out_word[LW-1:DW]))), int'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && out_word == '0 && in_ready, "R1 reset", int'(out_word), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R4: from the all-zero reference, 0101 costs 5/6/2/7, so even wins (word 10_0000)
    send(4'b0101, "R4 even pick");
    chk(out_word == 6'b10_0000, "R2 even word", int'(out_word), 'h20);
    send(4'b0000, "R4 back to zero");

    // R2 R3 R4: every ordered pair of flits, back to back
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        send(4'(a), "R4 sweep first");
        send(4'(b), "R4 sweep second");
      end

    // R5: drain, the wires keep the last word as reference
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(!out_valid && out_word == mprev, "R5 held after drain", int'(out_word), int'(mprev));

    // R6 R7: stall
    @(negedge clk);
    out_ready = 1'b0;
    send(4'h9, "R5 send after idle");
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 4'h6;
    #1;
    chk(!in_ready, "R6 ready low when stalled", int'(in_ready), 0);
    @(posedge clk);
    #1;
    chk(out_valid && out_word == mprev, "R7 hold under stall", int'(out_word), int'(mprev));
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk(in_ready, "R6 ready with out_ready", int'(in_ready), 1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    begin
      logic [LW-1:0] e;
      e = model(4'h6);
      mprev = e;
      chk(out_valid && out_word == e, "R6 stalled flit taken", int'(out_word), int'(e));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule